// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block decides, for a group of hardware threads that share one memory, whether each store-conditional succeeds. Every thread owns one reservation slot holding an address and a valid flag. Requests arrive on a single request port that carries an operation code, the issuing thread number and an address. A load-reserved records a reservation for its thread. A store-conditional reports its outcome one cycle later. A plain store removes reservations that other threads hold. The block stores no data. It only keeps reservation state and produces the pass/fail verdict.

A coherence invalidate port tells the block that a remote agent wants exclusive ownership of a line. A fresh reservation must be able to finish its store-conditional, so an invalidate that hits a reservation made recently is not applied at once. The block raises `inv_defer` in the same cycle and remembers the invalidate. It then applies it when a bounded window of `HOLD_CYCLES` cycles after the load-reserved closes. Outside the window an invalidate is applied at once. This bound prevents two threads from stealing each other's reservations forever.

Addresses are compared at a granule of `2**GRAN_LG2` bytes: the low `GRAN_LG2` address bits are ignored.

Top module: `lrsc_resv_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `sc_done`, `sc_fail` and `inv_defer` are 0. Reset clears every reservation, so a store-conditional issued after reset fails.
- R2: Request codes on `req_kind` are 2'b01 load-reserved, 2'b10 store-conditional and 2'b11 plain store. For each accepted store-conditional, `sc_done` is 1 for exactly the next cycle, and `sc_done` is 0 in every other cycle. `sc_fail` is 0 for success, following the common convention. A load-reserved followed by a store-conditional from the same thread to the same granule succeeds, and any address within the same 8-byte granule (default) matches.
- R3: A store-conditional fails (`sc_fail`=1) when its thread holds no reservation, or when it holds one for a different granule.
- R4: Every store-conditional, successful or failed, clears the reservation of its own thread, so a second one right after it fails.
- R5: A load-reserved by one thread clears any reservation that another thread holds on the same granule, and the issuing thread then holds the reservation.
- R6: A plain store, or a successful store-conditional, clears every reservation that other threads hold on the same granule. A plain store leaves the issuing thread's own reservation in place.
- R7: `inv_defer` is a combinational output. It is 1 in a cycle where `inv_valid` hits a valid reservation in any of the `HOLD_CYCLES` cycles that follow the load-reserved. The reservation survives to the end of that window, so a store-conditional issued inside the window still succeeds.
- R8: A deferred invalidate is applied when the window closes, even if no store-conditional has come. A store-conditional issued after the window then fails. An invalidate that arrives in the last cycle of the window is also deferred and is applied at the end of that cycle.
- R9: An invalidate that hits a reservation after its window has closed is applied at once with `inv_defer`=0, and the reservation is gone in the next cycle.
- R10: An invalidate to a granule that nobody has reserved has no effect and gives `inv_defer`=0.
- R11: Reservations of different threads on different granules are independent of each other.
- R12: A request with code 2'b00, or with `req_valid` low, has no effect on any reservation and produces no `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Request code: 01 load-reserved, 10 store-conditional, 11 plain store, 00 none |
| req_tid | input | TID_W | Issuing hardware thread |
| req_addr | input | ADDR_W | Byte address of the request |
| inv_valid | input | 1 | Coherence invalidate present this cycle |
| inv_addr | input | ADDR_W | Byte address being invalidated |
| sc_done | output | 1 | Store-conditional verdict valid (one cycle after the request) |
| sc_fail | output | 1 | 0 = store-conditional succeeded, 1 = failed |
| inv_defer | output | 1 | The invalidate this cycle is being held off |

## Verification
The store-conditional verdict is tried in several ways: after a matching load-reserved, with no reservation, and against an address in the same granule and in a neighbouring granule. These cases separate granule masking from full-address comparison. Further sequences put another thread's load-reserved, a plain store or a successful store-conditional between the reservation and the store-conditional. They tell apart clearing the other threads from clearing the issuing thread. Invalidates are placed at the first cycle of the window, at its last cycle and after it has closed. This shows whether the deferral bound counts exactly `HOLD_CYCLES`, and whether a pending invalidate is applied when the window expires or only when a new invalidate arrives.

// File: rtl/lrsc_pkg.sv
// Shared request encoding for the reservation tracker.
// Assumes a two-bit request code on the request port.
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LR   = 2'b01,
        OP_SC   = 2'b10,
        OP_ST   = 2'b11
    } lrsc_op_e;
endpackage

// File: rtl/resv_match.sv
// Granule comparator: flags every valid slot whose stored address lies in the
// same granule as the probe address. Assumes GRAN_LG2 < ADDR_W.
module resv_match #(
    parameter int NUM_HART = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3
) (
    input  logic [NUM_HART-1:0]             slot_valid,
    input  logic [NUM_HART-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]               probe_addr,
    output logic [NUM_HART-1:0]             hit
);
    localparam logic [ADDR_W-1:0] KEEP_MASK = ~((ADDR_W'(1) << GRAN_LG2) - ADDR_W'(1));

    for (genvar g = 0; g < NUM_HART; g++) begin : g_cmp
        // Compare one slot against the probe at granule resolution.
        always_comb begin
            hit[g] = slot_valid[g] &&
                     ((slot_addr[g] & KEEP_MASK) == (probe_addr & KEEP_MASK));
        end
    end
endmodule

// File: rtl/resv_slot.sv
// One thread's reservation slot with its livelock guard window.
// A load sets the window counter; while it is nonzero, invalidates are only
// remembered and are applied when the counter reaches zero.
// Assumes HOLD_CYCLES >= 1 and that set has priority over clear.
module resv_slot #(
    parameter int ADDR_W      = 32,
    parameter int HOLD_CYCLES = 16,
    parameter int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic              inv_hit,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              holding
);
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] win_cnt;
    logic             inv_pend;

    // Expose whether the guard window is still open.
    always_comb holding = (win_cnt != '0);

    // Update reservation, window counter and pending invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            addr     <= '0;
            win_cnt  <= '0;
            inv_pend <= 1'b0;
        end else if (set_en) begin
            valid    <= 1'b1;
            addr     <= set_addr;
            win_cnt  <= WIN_LOAD;
            inv_pend <= 1'b0;
        end else if (clr_en) begin
            valid    <= 1'b0;
            win_cnt  <= '0;
            inv_pend <= 1'b0;
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - CNT_W'(1);
            if (win_cnt == CNT_W'(1)) begin
                if (inv_pend || inv_hit) valid <= 1'b0;
                inv_pend <= 1'b0;
            end else if (inv_hit) begin
                inv_pend <= 1'b1;
            end
        end else if (inv_hit) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_outcome.sv
// Registers the store-conditional verdict so it appears one cycle after the
// request. Assumes the caller presents the decision combinationally.
module sc_outcome (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_req,
    input  logic sc_ok,
    output logic sc_done,
    output logic sc_fail
);
    // Capture the verdict for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_fail <= 1'b0;
        end else begin
            sc_done <= sc_req;
            sc_fail <= sc_req && !sc_ok;
        end
    end
endmodule

// File: rtl/lrsc_resv_unit.sv
// Reservation tracker for load-reserved / store-conditional across
// NUM_HART threads. Decodes one request per cycle and one coherence
// invalidate per cycle, drives set/clear into per-thread slots, and reports
// the store-conditional verdict one cycle later. Assumes req_tid < NUM_HART.
module lrsc_resv_unit #(
    parameter int NUM_HART    = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_LG2    = 3,
    parameter int HOLD_CYCLES = 16,
    parameter int TID_W       = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              sc_done,
    output logic              sc_fail,
    output logic              inv_defer
);
    import lrsc_pkg::*;

    lrsc_op_e                        op;
    logic                            is_lr, is_sc, is_st;
    logic [NUM_HART-1:0]             own_sel;
    logic [NUM_HART-1:0]             slot_valid;
    logic [NUM_HART-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_HART-1:0]             slot_hold;
    logic [NUM_HART-1:0]             req_hit, inv_match;
    logic [NUM_HART-1:0]             set_vec, clr_vec, inv_hit;
    logic                            sc_ok;

    // Decode the request code into one-hot operation strobes.
    always_comb begin
        op    = lrsc_op_e'(req_kind);
        is_lr = req_valid && (op == OP_LR);
        is_sc = req_valid && (op == OP_SC);
        is_st = req_valid && (op == OP_ST);
    end

    // Select the issuing thread's slot.
    always_comb begin
        own_sel = '0;
        for (int i = 0; i < NUM_HART; i++) begin
            own_sel[i] = (req_tid == TID_W'(i));
        end
    end

    resv_match #(.NUM_HART(NUM_HART), .ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_req_match (
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .probe_addr (req_addr),
        .hit        (req_hit)
    );

    resv_match #(.NUM_HART(NUM_HART), .ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_inv_match (
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .probe_addr (inv_addr),
        .hit        (inv_match)
    );

    // A store-conditional passes when its own slot matches the granule.
    always_comb sc_ok = |(req_hit & own_sel);

    // Build per-slot set, clear and invalidate-hit controls.
    always_comb begin
        for (int i = 0; i < NUM_HART; i++) begin
            set_vec[i] = is_lr && own_sel[i];
            clr_vec[i] = (is_sc && own_sel[i]) ||
                         (!own_sel[i] && req_hit[i] &&
                          (is_lr || is_st || (is_sc && sc_ok)));
            inv_hit[i] = inv_valid && inv_match[i];
        end
    end

    for (genvar g = 0; g < NUM_HART; g++) begin : g_slot
        resv_slot #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_vec[g]),
            .set_addr (req_addr),
            .clr_en   (clr_vec[g]),
            .inv_hit  (inv_hit[g]),
            .valid    (slot_valid[g]),
            .addr     (slot_addr[g]),
            .holding  (slot_hold[g])
        );
    end

    // Hold off the invalidate when any hit slot is inside its window.
    always_comb inv_defer = |(inv_hit & slot_hold);

    sc_outcome u_outcome (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_req  (is_sc),
        .sc_ok   (sc_ok),
        .sc_done (sc_done),
        .sc_fail (sc_fail)
    );
endmodule

// File: rtl/lrsc_resv_chk.sv
// Property checker for lrsc_resv_unit, attached with bind.
// Assumes the request code encoding of lrsc_pkg.
module lrsc_resv_chk #(
    parameter int ADDR_W = 32,
    parameter int TID_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [TID_W-1:0]  req_tid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              inv_valid,
    input logic              sc_done,
    input logic              sc_fail,
    input logic              inv_defer
);
    // R1: reset leaves the outputs quiet on the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sc_done && !sc_fail));

    // R2: every store-conditional yields a verdict in the next cycle
    a_r2_done_follows_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10) |=> sc_done);

    // R2: no verdict without a store-conditional one cycle earlier
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_kind == 2'b10) |=> !sc_done);

    // R4: a second back-to-back store-conditional from one thread fails
    a_r4_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10 &&
         $past(req_valid && req_kind == 2'b10) && $past(req_tid) == req_tid)
        |=> sc_fail);

    // R7: deferral only accompanies an invalidate
    a_r7_defer_needs_inv: assert property (@(posedge clk) disable iff (!rst_n)
        inv_defer |-> inv_valid);

    // R2: a failure flag never stands without a verdict
    a_r2_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fail |-> sc_done);

    logic unused_addr;
    always_comb unused_addr = ^req_addr;
endmodule

bind lrsc_resv_unit lrsc_resv_chk #(.ADDR_W(ADDR_W), .TID_W(TID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_tid   (req_tid),
    .req_addr  (req_addr),
    .inv_valid (inv_valid),
    .sc_done   (sc_done),
    .sc_fail   (sc_fail),
    .inv_defer (inv_defer)
);

// File: tb/lrsc_resv_unit_tb.sv
module lrsc_resv_unit_tb;
    localparam int HOLD = 16;
    localparam logic [1:0] K_NO = 2'b00, K_LR = 2'b01, K_SC = 2'b10, K_ST = 2'b11;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  tid;
        logic [31:0] addr;
        logic        iv;
        logic [31:0] ia;
        logic        edef;
        logic        edone;
        logic        efail;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{K_LR, 2'd0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R2 reserve
        '{K_SC, 2'd0, 32'h104, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R2 same granule passes
        '{K_SC, 2'd0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R4 consumed
        '{K_SC, 2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R3 no reservation
        '{K_LR, 2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R3 reserve
        '{K_SC, 2'd1, 32'h208, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R3 other granule
        '{K_LR, 2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R5 t1 reserves
        '{K_LR, 2'd2, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R5 t2 steals
        '{K_SC, 2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R5 t1 lost
        '{K_SC, 2'd2, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R5 t2 holds
        '{K_LR, 2'd0, 32'h300, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 reserve
        '{K_ST, 2'd1, 32'h306, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 foreign store
        '{K_SC, 2'd0, 32'h300, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R6 killed
        '{K_LR, 2'd2, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 reserve
        '{K_ST, 2'd2, 32'h404, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 own store
        '{K_SC, 2'd2, 32'h400, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R6 own kept
        '{K_LR, 2'd0, 32'h500, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R11
        '{K_LR, 2'd1, 32'h508, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R11
        '{K_SC, 2'd0, 32'h500, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R11 t0 ok
        '{K_SC, 2'd1, 32'h50C, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R11 t1 ok
        '{K_LR, 2'd0, 32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R12 reserve
        '{K_NO, 2'd1, 32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R12 null code
        '{K_SC, 2'd0, 32'h600, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R12 untouched
        '{K_LR, 2'd3, 32'h700, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R10 reserve
        '{K_NO, 2'd0, 32'h0,   1'b1, 32'h900, 1'b0, 1'b0, 1'b0}, // R10 foreign inv
        '{K_SC, 2'd3, 32'h700, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}  // R10 untouched
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [1:0]  req_tid = 2'd0;
    logic [31:0] req_addr = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_addr = '0;
    logic        sc_done, sc_fail, inv_defer;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lrsc_resv_unit #(.NUM_HART(4), .ADDR_W(32), .GRAN_LG2(3), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_tid(req_tid), .req_addr(req_addr), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .sc_done(sc_done), .sc_fail(sc_fail),
        .inv_defer(inv_defer)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check defer before the edge, result after it.
    task automatic step(input string req, input logic [1:0] k, input logic [1:0] t,
                        input logic [31:0] a, input logic iv, input logic [31:0] ia,
                        input logic edef, input logic edone, input logic efail);
        req_valid = (k != K_NO);
        req_kind  = k;
        req_tid   = t;
        req_addr  = a;
        inv_valid = iv;
        inv_addr  = ia;
        #1;
        if (iv) check({req, " inv_defer"}, inv_defer, edef);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        inv_valid = 1'b0;
        check({req, " sc_done"}, sc_done, edone);
        if (edone) check({req, " sc_fail"}, sc_fail, efail);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("idle", K_NO, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sc_done in reset", sc_done, 1'b0);
        check("R1 sc_fail in reset", sc_fail, 1'b0);
        rst_n = 1'b1;
        step("R1 sc after reset", K_SC, 2'd0, 32'h100, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            step("vector", VEC[i].kind, VEC[i].tid, VEC[i].addr, VEC[i].iv, VEC[i].ia,
                 VEC[i].edef, VEC[i].edone, VEC[i].efail);
        end

        // R7: invalidate right after reserve is deferred; SC inside window passes
        step("R7 lr", K_LR, 2'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R7 inv first cycle", K_NO, 2'd0, 32'h0, 1'b1, 32'h1000, 1'b1, 1'b0, 1'b0);
        step("R7 sc in window", K_SC, 2'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

        // R8: deferred invalidate applied at window end without a new invalidate
        step("R8 lr", K_LR, 2'd1, 32'h2000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R8 inv deferred", K_NO, 2'd0, 32'h0, 1'b1, 32'h2004, 1'b1, 1'b0, 1'b0);
        idle(HOLD - 1);
        step("R8 sc after window", K_SC, 2'd1, 32'h2000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

        // R8: invalidate in the last window cycle is deferred then applied
        step("R8 lr last", K_LR, 2'd2, 32'h3000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        idle(HOLD - 1);
        step("R8 inv last cycle", K_NO, 2'd0, 32'h0, 1'b1, 32'h3000, 1'b1, 1'b0, 1'b0);
        step("R8 sc after last", K_SC, 2'd2, 32'h3000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

        // R7: SC in the last window cycle still passes despite pending invalidate
        step("R7 lr", K_LR, 2'd3, 32'h4000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R7 inv pend", K_NO, 2'd0, 32'h0, 1'b1, 32'h4000, 1'b1, 1'b0, 1'b0);
        idle(HOLD - 2);
        step("R7 sc last cycle", K_SC, 2'd3, 32'h4000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

        // R9: invalidate after window is immediate
        step("R9 lr", K_LR, 2'd0, 32'h5000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        idle(HOLD);
        step("R9 inv late", K_NO, 2'd0, 32'h0, 1'b1, 32'h5000, 1'b0, 1'b0, 1'b0);
        step("R9 sc after inv", K_SC, 2'd0, 32'h5000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

        // R10: invalidate with no reservation anywhere is not deferred
        step("R10 inv empty", K_NO, 2'd0, 32'h0, 1'b1, 32'h7777, 1'b0, 1'b0, 1'b0);

        // R1: mid-run reset clears reservations
        step("R1 lr", K_LR, 2'd1, 32'h6000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 sc_done held in reset", sc_done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 sc after mid reset", K_SC, 2'd1, 32'h6000, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule